// File: doc/BRIEF.md
# Channel Refresh Sequencer

This controller keeps a bank of sample-and-hold channels alive by revisiting them one after another. For each visit it reads the channel's stored code from an external memory and places it on a converter code bus. One tick later it raises that channel's bit of a one-hot sample strobe for one tick. A visit therefore spans two ticks, and a full pass over sixteen channels spans thirty-two ticks. Ticks come from an internal oscillator pulse. When either the clock-select pin or the configuration bit is set, they come instead from every fourth pulse of an external clock.

A serial receiver outside the block marks the duration of each frame and reports each word it writes into the channel memory. While a frame is open, the visit already under way finishes and no new visit starts. When the frame closes, refreshing resumes at the channel that was due next. In immediate mode, selected by a pin or a configuration bit, the channel written last is served once before that. In burst mode, new codes simply take effect when their channel's turn comes. Power-up, or a pulse on the fill request, starts a fill. The fill writes code 4F2C hex into every channel in order, drives it out and samples it, and runs on the oscillator tick whatever the clock selection. A fill cannot be interrupted, and it raises a busy flag that tells the receiver to hold off.

Top module: `refresh_sequencer`

## Requirements
- R1: Outside fills, frames and priority visits, channels are visited in the cyclic order 0,1,…,15,0,…, and each visit presents the memory word at `mem_rd_addr` for that channel on `dac_code`.
- R2: A visit loads `dac_code` on its first tick. On its second tick it raises exactly one bit of `sample_strobe`, bit n for channel n, and holds it for one tick. `dac_code` never changes in the cycle the strobe rises, and neither output changes except on a tick or a fill request. Consecutive strobe rises are therefore two ticks apart.
- R3: The tick is `osc_tick` when `clk_sel_pin` and `cfg_ext_clk` are both 0. When either is 1, the tick is every fourth `ext_pulse`.
- R4: When `frame_active` rises, a visit whose code is already loaded still completes its strobe. No further visit starts while `frame_active` stays high.
- R5: In burst mode (`immed_pin` and `cfg_immed` both 0), the first visit after the frame closes is the channel after the last one strobed. Words written during the frame appear when their channel comes up.
- R6: In immediate mode (`immed_pin` or `cfg_immed` 1), the first visit after the frame closes is the channel of the last word written in the frame, with its new code. Its strobe rises within two ticks of the close. The cyclic order then continues with the channel after the last one strobed before the frame.
- R7: After reset release, or after `fill_n` is held low, channels 0 to 15 are visited in order with code 4F2C hex. Each channel is written once through the fill write port. Normal sequencing then starts at channel 0.
- R8: During a fill the tick is `osc_tick`, even if the external clock is selected.
- R9: `busy` is high from reset until the fill finishes. While it is high, `frame_active` and `wr_en` have no effect: the fill runs to the end, and no priority visit follows it.
- R10: While `rst_n` is low, `sample_strobe` is all zero, `dac_code` is 0 and `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a fill on release |
| fill_n | input | 1 | Synchronous active-low fill request |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| ext_pulse | input | 1 | One-cycle pulse per external clock period (synchronized) |
| clk_sel_pin | input | 1 | Selects the external clock |
| cfg_ext_clk | input | 1 | Configuration bit selecting the external clock |
| immed_pin | input | 1 | Selects immediate mode |
| cfg_immed | input | 1 | Configuration bit selecting immediate mode |
| frame_active | input | 1 | High while a serial frame is open |
| wr_en | input | 1 | Pulse when a serial word has been written to memory |
| wr_addr | input | 4 | Channel of that word |
| mem_rd_addr | output | 4 | Channel memory read address |
| mem_rd_data | input | 16 | Channel memory read data (combinational) |
| fill_wr_en | output | 1 | Fill write strobe into the channel memory |
| fill_wr_addr | output | 4 | Fill write address |
| fill_wr_data | output | 16 | Fill write data (4F2C hex) |
| dac_code | output | 16 | Code presented to the converter |
| sample_strobe | output | 16 | One-hot sample strobe per channel |
| busy | output | 1 | Fill in progress; serial input must wait |

## Verification
Two functions can fall in the same cycle: the close of a frame and a sequencer tick. When they coincide, the pending priority visit must start on that very tick, and the interrupted sequence must not start first. The bench waits for an oscillator pulse and drops `frame_active` in the same cycle. It then requires the written channel, with its new code, as the next strobe within two ticks, and after it the channel that was due. A second coincidence is a frame and a serial write that overlap a fill. Here the bench requires the full 4F2C sweep on oscillator timing, followed by channel 0 rather than the channel that was written.

// File: rtl/seq_pkg.sv
package seq_pkg;
    parameter int NUM_CH = 16;
    parameter int CODE_W = 16;
    parameter int EXT_DIV = 4;
    parameter logic [CODE_W-1:0] FILL_CODE = 16'h4F2C;
    localparam int CH_W = $clog2(NUM_CH);
    localparam int DIV_W = $clog2(EXT_DIV);

    typedef struct packed {
        logic [CH_W-1:0]   ptr;
        logic [CH_W-1:0]   cur;
        logic [CH_W-1:0]   pri_ch;
        logic              pend_b;
        logic              strobe_on;
        logic              pri_pend;
        logic              fill_on;
        logic [CH_W:0]     fill_cnt;
        logic [CODE_W-1:0] dac;
    } seq_state_t;
endpackage

// File: rtl/seq_tick_gen.sv
module seq_tick_gen
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic ext_pulse,
    input  logic use_ext,
    output logic tick
);
    logic [DIV_W-1:0] div_d, div_q;
    logic             div_tick;

    always_comb begin
        div_d    = div_q;
        div_tick = 1'b0;
        if (ext_pulse) begin
            if (div_q == DIV_W'(EXT_DIV - 1)) begin
                div_d    = '0;
                div_tick = 1'b1;
            end else begin
                div_d = div_q + 1'b1;
            end
        end
        tick = use_ext ? div_tick : osc_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/seq_onehot.sv
module seq_onehot
    import seq_pkg::*;
(
    input  logic            en,
    input  logic [CH_W-1:0] idx,
    output logic [NUM_CH-1:0] vec
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        assign vec[i] = en && (idx == CH_W'(i));
    end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_n,
    input  logic              osc_tick,
    input  logic              ext_pulse,
    input  logic              clk_sel_pin,
    input  logic              cfg_ext_clk,
    input  logic              immed_pin,
    input  logic              cfg_immed,
    input  logic              frame_active,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_addr,
    output logic [CH_W-1:0]   mem_rd_addr,
    input  logic [CODE_W-1:0] mem_rd_data,
    output logic              fill_wr_en,
    output logic [CH_W-1:0]   fill_wr_addr,
    output logic [CODE_W-1:0] fill_wr_data,
    output logic [CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0] sample_strobe,
    output logic              busy
);
    localparam logic [CH_W:0] FILL_END = (CH_W+1)'(NUM_CH);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    seq_state_t q, d;
    logic       tick;
    logic       use_ext;
    logic       immed_eff;

    assign use_ext   = (clk_sel_pin || cfg_ext_clk) && !q.fill_on;
    assign immed_eff = immed_pin || cfg_immed;

    seq_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .ext_pulse (ext_pulse),
        .use_ext   (use_ext),
        .tick      (tick)
    );

    seq_onehot u_strobe (
        .en  (q.strobe_on),
        .idx (q.cur),
        .vec (sample_strobe)
    );

    always_comb begin
        d           = q;
        fill_wr_en  = 1'b0;
        mem_rd_addr = q.pri_pend ? q.pri_ch : q.ptr;

        if (tick) begin
            if (q.pend_b) begin
                d.pend_b    = 1'b0;
                d.strobe_on = 1'b1;
            end else begin
                d.strobe_on = 1'b0;
                if (q.fill_on) begin
                    if (q.fill_cnt == FILL_END) begin
                        d.fill_on = 1'b0;
                    end else begin
                        d.dac      = FILL_CODE;
                        d.cur      = q.fill_cnt[CH_W-1:0];
                        d.pend_b   = 1'b1;
                        d.fill_cnt = q.fill_cnt + 1'b1;
                        fill_wr_en = 1'b1;
                    end
                end else if (!frame_active) begin
                    d.dac    = mem_rd_data;
                    d.cur    = mem_rd_addr;
                    d.pend_b = 1'b1;
                    if (q.pri_pend) begin
                        d.pri_pend = 1'b0;
                    end else begin
                        d.ptr = (q.ptr == LAST_CH) ? '0 : q.ptr + 1'b1;
                    end
                end
            end
        end

        if (wr_en && immed_eff && !q.fill_on) begin
            d.pri_pend = 1'b1;
            d.pri_ch   = wr_addr;
        end

        if (!fill_n) begin
            d          = '0;
            d.dac      = q.dac;
            d.fill_on  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.fill_on <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign fill_wr_addr = q.fill_cnt[CH_W-1:0];
    assign fill_wr_data = FILL_CODE;
    assign dac_code     = q.dac;
    assign busy         = q.fill_on;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
    import seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fill_n,
    input logic              tick,
    input logic              frame_active,
    input logic              busy,
    input logic [NUM_CH-1:0] strobe,
    input logic [CODE_W-1:0] dac_code
);
    // R1, R2: at most one channel sampled at a time
    a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe));

    // R2: the code is settled when a strobe rises
    a_r2_code_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|strobe) |-> $stable(dac_code));

    // R2: outputs move only on a tick or a fill request
    a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && fill_n) |=> ($stable(strobe) && $stable(dac_code)));

    // R4: no new code is loaded while a frame is open outside a fill
    a_r4_frame_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !busy && fill_n) |=> $stable(dac_code));

    // R7: any strobe during a fill samples the fill code
    a_r7_fill_code: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (strobe != '0)) |-> (dac_code == FILL_CODE));
endmodule

bind refresh_sequencer seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_n       (fill_n),
    .tick         (tick),
    .frame_active (frame_active),
    .busy         (busy),
    .strobe       (sample_strobe),
    .dac_code     (dac_code)
);

// File: tb/tb_refresh_sequencer.sv
`timescale 1ns/1ps
module tb_refresh_sequencer;
    localparam logic [15:0] FILL = 16'h4F2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, fill_n = 1'b1;
    logic        osc_tick = 1'b0, ext_pulse = 1'b0;
    logic        clk_sel_pin = 1'b0, cfg_ext_clk = 1'b0;
    logic        immed_pin = 1'b0, cfg_immed = 1'b0;
    logic        frame_active = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        fill_wr_en;
    logic [3:0]  fill_wr_addr;
    logic [15:0] fill_wr_data;
    logic [15:0] dac_code;
    logic [15:0] sample_strobe;
    logic        busy;

    logic [15:0] mem [16];
    assign mem_rd_data = mem[mem_rd_addr];

    refresh_sequencer dut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int osc_per = 8, ext_per = 0;
    int ev_n = 0;
    int ev_ch [2048];
    int ev_code [2048];
    int ev_cyc [2048];
    logic [15:0] fill_mask = '0;
    logic [15:0] prev_strobe = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int strobe_idx(input logic [15:0] s);
        for (int i = 0; i < 16; i++) if (s[i]) return i;
        return -1;
    endfunction

    // tick sources, driven just after the falling edge
    initial begin
        int oc = 0, ec = 0;
        forever begin
            @(negedge clk);
            oc++;
            osc_tick = (oc % osc_per) == 0;
            ec++;
            ext_pulse = (ext_per != 0) && ((ec % ext_per) == 0);
        end
    end

    // output monitor, sampled well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            cyc++;
            if (sample_strobe != '0 && sample_strobe != prev_strobe && ev_n < 2048) begin
                ev_ch[ev_n]   = strobe_idx(sample_strobe);
                ev_code[ev_n] = int'(dac_code);
                ev_cyc[ev_n]  = cyc;
                ev_n++;
            end
            prev_strobe = sample_strobe;
            if (fill_wr_en && fill_wr_data == FILL) fill_mask[fill_wr_addr] = 1'b1;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_events(input int target);
        int guard = 0;
        while (ev_n < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        #3;
    endtask

    task automatic serial_write(input int ch, input logic [15:0] code);
        @(negedge clk); #1;
        wr_addr = 4'(ch);
        wr_en   = 1'b1;
        mem[ch] = code;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_busy_low();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk); #3;
            guard++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        int s, last, pri, pri2, rel;
        for (int i = 0; i < 16; i++) mem[i] = 16'hA000 ^ 16'(i * 16'h0123);

        // R10: reset state
        wait_cyc(5);
        chk(sample_strobe == '0, "R10 strobe in reset", int'(sample_strobe), 0);
        chk(dac_code == '0, "R10 code in reset", int'(dac_code), 0);
        chk(busy == 1'b1, "R10 busy in reset", int'(busy), 1);

        // R7, R8: power-up fill while the fast external clock is selected
        clk_sel_pin = 1'b1;
        ext_per = 1;
        s = ev_n;
        rst_n = 1'b1;
        wait_busy_low();
        chk(ev_n - s == 16, "R7 fill visit count", ev_n - s, 16);
        for (int k = 0; k < 16; k++) begin
            chk(ev_ch[s+k] == k, "R7 fill order", ev_ch[s+k], k);
            chk(ev_code[s+k] == int'(FILL), "R7 fill code", ev_code[s+k], int'(FILL));
            if (k > 0)
                chk(ev_cyc[s+k] - ev_cyc[s+k-1] == 2*osc_per, "R8 fill on oscillator tick",
                    ev_cyc[s+k] - ev_cyc[s+k-1], 2*osc_per);
        end
        chk(fill_mask == 16'hFFFF, "R7 fill writes", int'(fill_mask), 16'hFFFF);
        chk(busy == 1'b0, "R9 busy after fill", int'(busy), 0);

        // R1, R2: plain sequencing on the oscillator
        clk_sel_pin = 1'b0;
        ext_per = 0;
        s = ev_n;
        wait_events(s + 33);
        for (int k = 0; k < 32; k++) begin
            chk(ev_ch[s+k] == k % 16, "R1 sequence order", ev_ch[s+k], k % 16);
            chk(ev_code[s+k] == int'(mem[k % 16]), "R1 sequence code", ev_code[s+k], int'(mem[k % 16]));
            chk(ev_cyc[s+k+1] - ev_cyc[s+k] == 16, "R2 two ticks per visit",
                ev_cyc[s+k+1] - ev_cyc[s+k], 16);
        end

        // R3: external clock through the config bit, then the pin, then none
        ext_per = 3;
        cfg_ext_clk = 1'b1;
        s = ev_n;
        wait_events(s + 6);
        for (int k = 3; k < 6; k++)
            chk(ev_cyc[s+k] - ev_cyc[s+k-1] == 24, "R3 config bit selects divided clock",
                ev_cyc[s+k] - ev_cyc[s+k-1], 24);
        cfg_ext_clk = 1'b0;
        clk_sel_pin = 1'b1;
        s = ev_n;
        wait_events(s + 6);
        for (int k = 3; k < 6; k++)
            chk(ev_cyc[s+k] - ev_cyc[s+k-1] == 24, "R3 pin selects divided clock",
                ev_cyc[s+k] - ev_cyc[s+k-1], 24);
        clk_sel_pin = 1'b0;
        s = ev_n;
        wait_events(s + 6);
        for (int k = 3; k < 6; k++)
            chk(ev_cyc[s+k] - ev_cyc[s+k-1] == 16, "R3 oscillator when unselected",
                ev_cyc[s+k] - ev_cyc[s+k-1], 16);
        ext_per = 0;

        // R4, R5: burst frame opened while a code is loaded
        s = ev_n;
        wait_events(s + 1);
        last = ev_ch[ev_n-1];
        wait_cyc(10);
        frame_active = 1'b1;
        s = ev_n;
        serial_write((last + 5) % 16, 16'h1111);
        serial_write((last + 9) % 16, 16'h2222);
        wait_cyc(200);
        chk(ev_n - s == 1, "R4 only the loaded visit completes", ev_n - s, 1);
        chk(ev_ch[s] == (last + 1) % 16, "R4 completed channel", ev_ch[s], (last + 1) % 16);
        frame_active = 1'b0;
        s = ev_n;
        wait_events(s + 16);
        for (int k = 0; k < 16; k++) begin
            chk(ev_ch[s+k] == (last + 2 + k) % 16, "R5 burst resume order",
                ev_ch[s+k], (last + 2 + k) % 16);
            chk(ev_code[s+k] == int'(mem[(last + 2 + k) % 16]), "R5 burst new codes",
                ev_code[s+k], int'(mem[(last + 2 + k) % 16]));
        end

        // R6: immediate via pin, frame closes on the same cycle as a tick
        immed_pin = 1'b1;
        s = ev_n;
        wait_events(s + 1);
        last = ev_ch[ev_n-1];
        wait_cyc(10);
        frame_active = 1'b1;
        pri2 = (last + 4) % 16;
        pri  = (last + 8) % 16;
        serial_write(pri2, 16'h3333);
        serial_write(pri, 16'h4444);
        wait_cyc(40);
        s = ev_n;
        do begin
            @(negedge clk); #1;
        end while (!osc_tick);
        frame_active = 1'b0;
        rel = cyc;
        wait_events(s + 3);
        chk(ev_ch[s] == pri, "R6 priority channel first", ev_ch[s], pri);
        chk(ev_code[s] == 16'h4444, "R6 priority code", ev_code[s], 16'h4444);
        chk(ev_cyc[s] - rel <= 2*osc_per + 1, "R6 priority within two ticks", ev_cyc[s] - rel, 2*osc_per);
        chk(ev_ch[s+1] == (last + 2) % 16, "R6 resume after priority", ev_ch[s+1], (last + 2) % 16);
        chk(ev_ch[s+2] == (last + 3) % 16, "R6 order continues", ev_ch[s+2], (last + 3) % 16);
        immed_pin = 1'b0;

        // R6: immediate via config bit
        cfg_immed = 1'b1;
        s = ev_n;
        wait_events(s + 1);
        last = ev_ch[ev_n-1];
        wait_cyc(3);
        frame_active = 1'b1;
        pri = (last + 6) % 16;
        serial_write(pri, 16'h5555);
        wait_cyc(30);
        s = ev_n;
        frame_active = 1'b0;
        wait_events(s + 2);
        chk(ev_ch[s] == pri, "R6 config bit priority", ev_ch[s], pri);
        chk(ev_ch[s+1] == (last + 1) % 16, "R6 config bit resume", ev_ch[s+1], (last + 1) % 16);

        // R7, R9: fill request with frame and write that must be ignored
        wait_cyc(5);
        fill_n = 1'b0;
        wait_cyc(2);
        fill_n = 1'b1;
        chk(busy == 1'b1, "R9 busy during fill", int'(busy), 1);
        frame_active = 1'b1;
        serial_write(9, 16'h6666);
        mem[9] = FILL;
        s = ev_n;
        wait_busy_low();
        chk(ev_n - s == 16, "R9 fill not paused by frame", ev_n - s, 16);
        for (int k = 0; k < 16; k++)
            chk(ev_ch[s+k] == k && ev_code[s+k] == int'(FILL), "R7 refill sweep", ev_ch[s+k], k);
        for (int i = 0; i < 16; i++) mem[i] = FILL;
        wait_cyc(20);
        s = ev_n;
        frame_active = 1'b0;
        cfg_immed = 1'b0;
        wait_events(s + 2);
        chk(ev_ch[s] == 0, "R9 write during fill ignored", ev_ch[s], 0);
        chk(ev_ch[s+1] == 1, "R7 sequence restarts at 0", ev_ch[s+1], 1);

        summary();
    end
endmodule